// File: doc/BRIEF.md
# Fast-to-Slow Bus Cycle Bridge

This block connects a processor core that runs on a fast clock to a slow host bus that is timed by an external phase clock (PHI2). When the core raises a request, the block stalls the core. It then waits for the start of a complete PHI2 high phase in which the bus-available input (BA) is asserted. For that whole high phase it drives address, write data and the read/write strobe onto the host bus. When PHI2 falls, it samples the read data, tristates its drivers, and gives the core a one-cycle acknowledge so the core can continue at full speed.

PHI2 and BA are asynchronous to the fast clock. Each passes through a two-stage synchronizer. PHI2 edges are found by comparing the synchronized sample with the one taken a cycle earlier.

The controller has five states. IDLE waits for a request. If PHI2 is already high when the request arrives, the controller moves to WAIT_LOW, which lets that partial phase go by. Otherwise it moves to WAIT_RISE. WAIT_LOW moves to WAIT_RISE once PHI2 is low. In WAIT_RISE, a rising edge with BA high leads to DRIVE, and a rising edge with BA low leads back to WAIT_LOW. DRIVE moves to DONE on the falling edge. DONE pulses the acknowledge and returns to IDLE.

Top module: `slowbus_bridge`

## Requirements
- R1: After reset, host_oe is 0, host_rnw is 1, host_addr and host_dout are 0, and ack and stall are 0.
- R2: With a request pending and BA high, host_oe goes to 1 on the third fast clock edge after PHI2 rises. On that edge host_addr carries the request address and host_rnw is 0 for a write or 1 for a read. host_dout carries the write data for a write and stays 0 for a read.
- R3: A request that arrives while PHI2 is high does not use that high phase. The drivers stay off until PHI2 has gone low and risen again.
- R4: If BA is low when PHI2 rises, that phase is skipped and the bridge retries on the next rising edge.
- R5: stall is 1 in the same cycle that req_valid is seen in IDLE. It stays 1 until the access ends and is 0 in the acknowledge cycle.
- R6: On the third fast clock edge after PHI2 falls, host_oe returns to 0, host_addr and host_dout to 0, and host_rnw to 1.
- R7: On that same edge, ack is 1 for exactly one cycle. For a read, rdata then holds the value that host_din had while PHI2 fell.
- R8: Changes on BA while the drivers are enabled do not end or alter the access.
- R9: With no request pending, PHI2 activity never enables the drivers or raises stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Core access request, held until ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| stall | output | 1 | Core must hold its state |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Read data captured at PHI2 fall |
| phi2 | input | 1 | Slow bus phase clock, asynchronous |
| ba | input | 1 | Bus available, asynchronous |
| host_din | input | DW | Data read from the host bus |
| host_addr | output | AW | Address toward host bus |
| host_dout | output | DW | Write data toward host bus |
| host_rnw | output | 1 | Read (1) / write (0) strobe |
| host_oe | output | 1 | Output enable for address, data and strobe drivers |

## Verification
Every PHI2 or BA change passes through two synchronizer stages plus the state register. A host-side result is therefore due on the third rising clock edge after the bench moves the input. The bench changes these inputs on a falling clock edge. After the second rising edge it checks that nothing has happened yet, and after the third it checks the new value, sampling each time on the next falling edge. stall responds combinationally to req_valid and is checked in the same half cycle in which the request is applied. The acknowledge and read data are checked on the same edge as the driver release, and the bench checks one edge later that the acknowledge has dropped.

// File: rtl/slowbus_pkg.sv
package slowbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_LOW  = 3'd1,
        ST_WAIT_RISE = 3'd2,
        ST_DRIVE     = 3'd3,
        ST_DONE      = 3'd4
    } bridge_state_t;

    localparam int SYNC_PHI = 0;
    localparam int SYNC_BA  = 1;
    localparam int SYNC_W   = 2;
endpackage

// File: rtl/slowbus_sync.sv
module slowbus_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain[LAST];
    end

    assign level = chain[LAST];
    assign rise  = chain[LAST] & ~prev_q;
    assign fall  = ~chain[LAST] & prev_q;
endmodule

// File: rtl/slowbus_fsm.sv
module slowbus_fsm
    import slowbus_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          phi_high,
    input  logic          phi_rise,
    input  logic          phi_fall,
    input  logic          ba_high,
    output bridge_state_t state,
    output logic          capture,
    output logic          latch_rd,
    output logic          drive,
    output logic          done,
    output logic          busy
);
    bridge_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = phi_high ? ST_WAIT_LOW : ST_WAIT_RISE;
            ST_WAIT_LOW:  if (!phi_high) state_d = ST_WAIT_RISE;
            ST_WAIT_RISE: if (phi_rise)  state_d = ba_high ? ST_DRIVE : ST_WAIT_LOW;
            ST_DRIVE:     if (phi_fall)  state_d = ST_DONE;
            ST_DONE:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        capture  = 1'b0;
        latch_rd = 1'b0;
        drive    = 1'b0;
        done     = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                capture = req_valid;
                busy    = req_valid;
            end
            ST_WAIT_LOW, ST_WAIT_RISE: busy = 1'b1;
            ST_DRIVE: begin
                drive    = 1'b1;
                busy     = 1'b1;
                latch_rd = phi_fall;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/slowbus_drv.sv
module slowbus_drv #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          latch_rd,
    input  logic          drive,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] host_din,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] host_addr,
    output logic [DW-1:0] host_dout,
    output logic          host_rnw,
    output logic          host_oe
);
    logic          we_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (capture) begin
            we_q    <= req_write;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  rdata_q <= '0;
        else if (latch_rd && !we_q)  rdata_q <= host_din;
    end

    always_comb begin
        host_oe   = drive;
        host_addr = drive ? addr_q : '0;
        host_rnw  = drive ? !we_q : 1'b1;
        host_dout = (drive && we_q) ? wdata_q : '0;
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/slowbus_bridge.sv
module slowbus_bridge
    import slowbus_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          stall,
    output logic          ack,
    output logic [DW-1:0] rdata,
    input  logic          phi2,
    input  logic          ba,
    input  logic [DW-1:0] host_din,
    output logic [AW-1:0] host_addr,
    output logic [DW-1:0] host_dout,
    output logic          host_rnw,
    output logic          host_oe
);
    logic [SYNC_W-1:0] s_level, s_rise, s_fall;
    bridge_state_t     state;
    logic              capture, latch_rd, drive;

    slowbus_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ba, phi2}),
        .level    (s_level),
        .rise     (s_rise),
        .fall     (s_fall)
    );

    slowbus_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .phi_high  (s_level[SYNC_PHI]),
        .phi_rise  (s_rise[SYNC_PHI]),
        .phi_fall  (s_fall[SYNC_PHI]),
        .ba_high   (s_level[SYNC_BA]),
        .state     (state),
        .capture   (capture),
        .latch_rd  (latch_rd),
        .drive     (drive),
        .done      (ack),
        .busy      (stall)
    );

    slowbus_drv #(.AW(AW), .DW(DW)) drv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (capture),
        .latch_rd  (latch_rd),
        .drive     (drive),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .host_din  (host_din),
        .rdata     (rdata),
        .host_addr (host_addr),
        .host_dout (host_dout),
        .host_rnw  (host_rnw),
        .host_oe   (host_oe)
    );

    logic unused_ok;
    assign unused_ok = ^{s_rise[SYNC_BA], s_fall[SYNC_BA], state};
endmodule

// File: rtl/slowbus_bridge_chk.sv
module slowbus_bridge_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          stall,
    input logic          ack,
    input logic [AW-1:0] host_addr,
    input logic [DW-1:0] host_dout,
    input logic          host_rnw,
    input logic          host_oe
);
    // R6: released bus shows read strobe and zeroed lines
    p_release_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !host_oe |-> (host_rnw && host_addr == '0 && host_dout == '0));

    // R7: acknowledge lasts one cycle
    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R7: acknowledge only follows a driven phase
    p_ack_after_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(host_oe));

    // R5: core is stalled while drivers are on, released at ack
    p_stall_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_oe |-> stall);
    p_no_stall_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !stall);

    // R8: address and data hold steady while driving
    p_drive_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_oe && $past(host_oe)) |-> ($stable(host_addr) && $stable(host_dout) && $stable(host_rnw)));

    // R9: drivers only turn on for a stalled core
    p_oe_needs_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_oe) |-> $past(stall));
endmodule

bind slowbus_bridge slowbus_bridge_chk #(.AW(AW), .DW(DW)) chk_i (.*);

// File: tb/slowbus_bridge_tb.sv
module slowbus_bridge_tb_top;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          stall, ack;
    logic [DW-1:0] rdata;
    logic          phi2 = 1'b0;
    logic          ba = 1'b1;
    logic [DW-1:0] host_din = '0;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_dout;
    logic          host_rnw, host_oe;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    slowbus_bridge #(.AW(AW), .DW(DW)) dut_i (.*);

    // {write, start_high, ba_low_phases[1:0], addr[15:0], wdata[7:0], din[7:0]}
    localparam int VN = 6;
    localparam logic [35:0] VEC [VN] = '{
        {1'b0, 1'b0, 2'd0, 16'h1234, 8'h00, 8'hA5},
        {1'b1, 1'b0, 2'd0, 16'hD020, 8'h3C, 8'h00},
        {1'b0, 1'b1, 2'd0, 16'hFFFF, 8'h00, 8'h5A},
        {1'b1, 1'b1, 2'd1, 16'h0001, 8'hFF, 8'h11},
        {1'b0, 1'b0, 2'd2, 16'h8000, 8'h00, 8'hC3},
        {1'b0, 1'b0, 2'd1, 16'h0400, 8'h00, 8'hFF}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic access(input bit wr, input bit start_high, input int ba_low,
                          input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [DW-1:0] din, input bit ba_drop_mid);
        logic [DW-1:0] rd_before;
        rd_before = rdata;
        phi2 = start_high;
        ba = 1'b1;
        clocks(6);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        #0.5;
        chk(stall === 1'b1, "R5 stall on request", stall, 1);
        if (start_high) begin
            clocks(4);
            chk(host_oe === 1'b0, "R3 partial phase unused", host_oe, 0);
            phi2 = 1'b0;
            clocks(6);
            chk(host_oe === 1'b0, "R3 still waiting in low phase", host_oe, 0);
        end
        for (int k = 0; k < ba_low; k++) begin
            ba = 1'b0; phi2 = 1'b1;
            clocks(6);
            chk(host_oe === 1'b0, "R4 phase skipped with BA low", host_oe, 0);
            chk(stall === 1'b1, "R5 stall while waiting", stall, 1);
            phi2 = 1'b0;
            clocks(3);
            ba = 1'b1;
            clocks(3);
        end
        phi2 = 1'b1;
        clocks(2);
        chk(host_oe === 1'b0, "R2 not driven before third edge", host_oe, 0);
        clocks(1);
        chk(host_oe === 1'b1, "R2 drive on third edge", host_oe, 1);
        chk(host_addr === a, "R2 address", host_addr, a);
        chk(host_rnw === !wr, "R2 strobe", host_rnw, !wr);
        chk(host_dout === (wr ? wd : '0), "R2 write data", host_dout, wr ? wd : '0);
        if (ba_drop_mid) ba = 1'b0;
        clocks(5);
        chk(host_oe === 1'b1 && host_addr === a, "R8 access holds through phase", host_oe, 1);
        chk(ack === 1'b0 && stall === 1'b1, "R5 stalled during drive", {ack, stall}, 2'b01);
        host_din = din;
        phi2 = 1'b0;
        clocks(2);
        chk(host_oe === 1'b1, "R6 still driven before third edge", host_oe, 1);
        clocks(1);
        chk(host_oe === 1'b0 && host_rnw === 1'b1 && host_addr === '0 && host_dout === '0,
            "R6 released", {host_oe, host_rnw}, 2'b01);
        chk(ack === 1'b1, "R7 ack pulse", ack, 1);
        chk(stall === 1'b0, "R5 stall low at ack", stall, 0);
        chk(rdata === (wr ? rd_before : din), "R7 read data", rdata, wr ? rd_before : din);
        req_valid = 1'b0;
        host_din = 8'h00;
        ba = 1'b1;
        clocks(1);
        chk(ack === 1'b0 && stall === 1'b0, "R7 ack one cycle", {ack, stall}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        clocks(3);
        // R1 reset state
        chk(host_oe === 1'b0 && host_rnw === 1'b1, "R1 reset strobes", {host_oe, host_rnw}, 2'b01);
        chk(host_addr === '0 && host_dout === '0, "R1 reset lines", host_addr, 0);
        chk(ack === 1'b0 && stall === 1'b0, "R1 reset handshake", {ack, stall}, 0);
        rst_n = 1'b1;
        clocks(2);

        for (int v = 0; v < VN; v++) begin
            access(VEC[v][35], VEC[v][34], int'(VEC[v][33:32]), VEC[v][31:16],
                   VEC[v][15:8], VEC[v][7:0], 1'b0);
        end

        // R8 BA drops during the driven phase
        access(1'b0, 1'b0, 0, 16'hBEEF, 8'h00, 8'h77, 1'b1);

        // R9 PHI2 toggling with no request
        for (int c = 0; c < 3; c++) begin
            phi2 = 1'b1; clocks(6);
            chk(host_oe === 1'b0 && stall === 1'b0, "R9 idle high phase", {host_oe, stall}, 0);
            phi2 = 1'b0; clocks(6);
            chk(host_oe === 1'b0 && ack === 1'b0, "R9 idle low phase", {host_oe, ack}, 0);
        end

        // R3 request arriving right as PHI2 rises
        phi2 = 1'b0; clocks(6);
        phi2 = 1'b1; clocks(2);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0F0F;
        clocks(3);
        chk(host_oe === 1'b0, "R3 rise at request not used", host_oe, 0);
        phi2 = 1'b0; clocks(6);
        phi2 = 1'b1; clocks(3);
        chk(host_oe === 1'b1 && host_addr === 16'h0F0F, "R3 next full phase used", host_addr, 16'h0F0F);
        host_din = 8'h42;
        phi2 = 1'b0; clocks(3);
        chk(ack === 1'b1 && rdata === 8'h42, "R7 read after deferred start", rdata, 8'h42);
        req_valid = 1'b0;
        clocks(2);

        // R1 reset in mid access
        req_valid = 1'b1; phi2 = 1'b1; clocks(8);
        rst_n = 1'b0; #0.5;
        chk(host_oe === 1'b0 && host_rnw === 1'b1 && stall === 1'b1, "R1 async reset releases bus",
            {host_oe, host_rnw}, 2'b01);
        req_valid = 1'b0; clocks(1);
        chk(stall === 1'b0 && ack === 1'b0, "R1 reset handshake idle", {stall, ack}, 0);

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule